// File: doc/BRIEF.md
# Prescaled Up/Down Core Timer

This block is a 16-bit core timer. It steps its count by one, up or down, each time a block prescaler produces a tick. The prescaler divides the system clock by 2, 4, 8 or 16. When the count wraps past either end, it can restart from an externally supplied reload value. A capture event can also force the count to zero. Each wrap inverts a toggle latch, and that latch can be sent to an output pin. Software may also set or clear the latch directly.

The CPU sees two 16-bit registers through a single-address-bit port: a control register and the count register. Both can be written at any time and read back combinationally. A run enable gates counting. A one-cycle wrap pulse is provided for interrupt logic or for chaining to other timers.

Top module: `ptmr_core`

## Requirements
- R1: Register address 0 selects control and address 1 selects the count. A write lands at the clock edge where `reg_wr_en` is high, and `reg_rdata` shows the addressed register in the same cycle. Control bits 13, 8 and 6..0 always read as 0. After reset, control and count both read 0x0000.
- R2: The count changes only on a prescaler tick while `run_en` is high, and then by exactly one. It holds when `run_en` is low and there is no write or clear.
- R3: Control bits [12:11] set the tick period in clock cycles: 00 gives 4, 01 gives 2, 10 gives 16 and 11 gives 8.
- R4: Counting up from 0xFFFF wraps to 0x0000, and counting down from 0x0000 wraps to 0xFFFF, when control bit 15 is 0.
- R5: When control bit 15 is 1, a wrap in either direction loads the count from `reload_val` in place of the wrap value.
- R6: When control bit 14 is 1, a high `cap_evt` sets the count to zero at the next edge. When bit 14 is 0, `cap_evt` has no effect on the count.
- R7: Control bit 10 is a toggle latch. It inverts on every wrap, and a control write loads it from `reg_wdata[10]`. A control write takes precedence over a wrap in the same cycle.
- R8: `tgl_out` equals the latch when control bit 9 is 1, and is 0 when bit 9 is 0.
- R9: `wrap_pulse` is high for exactly one cycle, namely the cycle in which the count first shows its post-wrap value.
- R10: A CPU write to the count takes precedence over a tick in the same cycle. An enabled capture clear takes precedence over counting and reload, and in that case no wrap, latch toggle or pulse occurs.
- R11: A change of bits [12:11] restarts the prescaler. If the write lands at edge W, the first count change under the new period N appears at edge W+N+1.
- R12: Control bit 7 selects direction: 0 counts up and 1 counts down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the base of the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = count |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| run_en | input | 1 | Counting enable |
| cap_evt | input | 1 | Capture event (clears the count when enabled) |
| reload_val | input | 16 | Value loaded on a wrap when reload is enabled |
| tgl_out | output | 1 | Toggle latch gated by the output enable |
| wrap_pulse | output | 1 | One-cycle pulse after each overflow or underflow |

## Verification
On every cycle, the assertions check the following: the hold when stopped, the clear on capture, the priority of CPU writes, the inversion of the latch on a wrap, the wrap value without reload, and the single-cycle wrap pulse with its placement. Other behaviour can only be shown by the bench scenarios. These are the tick period for each divider code, the prescaler restart timing after a divider change, the reload in both directions, the gating of the output pin, and the way `cap_evt` is ignored when clearing is disabled.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    // Control register field positions (software-visible layout)
    localparam int unsigned POS_RELOAD = 15;
    localparam int unsigned POS_CLRCAP = 14;
    localparam int unsigned POS_DIV_HI = 12;
    localparam int unsigned POS_DIV_LO = 11;
    localparam int unsigned POS_TGL    = 10;
    localparam int unsigned POS_OUTEN  = 9;
    localparam int unsigned POS_DOWN   = 7;

    typedef enum logic [1:0] {
        DIV4  = 2'b00,
        DIV2  = 2'b01,
        DIV16 = 2'b10,
        DIV8  = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic     reload_en;
        logic     clr_on_cap;
        div_sel_e div_sel;
        logic     tgl;
        logic     out_en;
        logic     down;
    } ctrl_t;

    function automatic int unsigned div_of(div_sel_e s);
        case (s)
            DIV2:    return 2;
            DIV4:    return 4;
            DIV8:    return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [15:0] ctrl_pack(ctrl_t c);
        logic [15:0] img;
        img             = '0;
        img[POS_RELOAD] = c.reload_en;
        img[POS_CLRCAP] = c.clr_on_cap;
        img[POS_DIV_HI] = c.div_sel[1];
        img[POS_DIV_LO] = c.div_sel[0];
        img[POS_TGL]    = c.tgl;
        img[POS_OUTEN]  = c.out_en;
        img[POS_DOWN]   = c.down;
        return img;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [15:0] img);
        ctrl_t c;
        c.reload_en  = img[POS_RELOAD];
        c.clr_on_cap = img[POS_CLRCAP];
        c.div_sel    = div_sel_e'({img[POS_DIV_HI], img[POS_DIV_LO]});
        c.tgl        = img[POS_TGL];
        c.out_en     = img[POS_OUTEN];
        c.down       = img[POS_DOWN];
        return c;
    endfunction

endpackage

// File: rtl/ptmr_presc.sv
module ptmr_presc
    import ptmr_pkg::*;
#(
    parameter int unsigned PRE_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  div_sel_e sel,
    output logic     tick
);
    div_sel_e           sel_q;
    logic [PRE_W-1:0]   pcnt;
    logic [PRE_W-1:0]   last;
    logic               sel_same;

    assign last     = PRE_W'(div_of(sel) - 1);
    assign sel_same = (sel == sel_q);
    assign tick     = sel_same && (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= DIV4;
            pcnt  <= '0;
        end else if (!sel_same) begin
            sel_q <= sel;
            pcnt  <= '0;
        end else if (tick) begin
            pcnt  <= '0;
        end else begin
            pcnt  <= pcnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic         down,
    input  logic         reload_en,
    input  logic [W-1:0] reload_val,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         wrap_evt
);
    logic         at_end;
    logic [W-1:0] wrap_val;
    logic [W-1:0] cnt_d;

    assign at_end   = down ? (cnt == '0) : (cnt == '1);
    assign wrap_val = reload_en ? reload_val : (down ? '1 : '0);
    assign wrap_evt = step && at_end && !wr_cnt && !clr;

    always_comb begin
        cnt_d = cnt;
        if (wr_cnt)        cnt_d = wdata;
        else if (clr)      cnt_d = '0;
        else if (step) begin
            if (at_end)    cnt_d = wrap_val;
            else if (down) cnt_d = cnt - W'(1);
            else           cnt_d = cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_d;
    end
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
    import ptmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic [15:0] wdata,
    input  logic        wrap_evt,
    output ctrl_t       ctrl
);
    always_ff @(posedge clk) begin
        if (rst)           ctrl     <= '0;
        else if (wr_ctrl)  ctrl     <= ctrl_unpack(wdata);
        else if (wrap_evt) ctrl.tgl <= ~ctrl.tgl;
    end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              run_en,
    input  logic              cap_evt,
    input  logic [DATA_W-1:0] reload_val,
    output logic              tgl_out,
    output logic              wrap_pulse
);
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CNT  = 1'b1;

    ctrl_t             ctrl_q;
    logic [15:0]       ctrl_img;
    logic [DATA_W-1:0] cnt_q;
    logic              tick;
    logic              wrap_evt;
    logic              wr_ctrl;
    logic              wr_cnt;
    logic              clr;

    assign wr_ctrl  = reg_wr_en && (reg_addr == ADDR_CTRL);
    assign wr_cnt   = reg_wr_en && (reg_addr == ADDR_CNT);
    assign clr      = cap_evt && ctrl_q.clr_on_cap;
    assign ctrl_img = ctrl_pack(ctrl_q);

    ptmr_presc #(.PRE_W(PRE_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.div_sel),
        .tick (tick)
    );

    ptmr_count #(.W(DATA_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .wr_cnt     (wr_cnt),
        .wdata      (reg_wdata),
        .step       (tick && run_en),
        .down       (ctrl_q.down),
        .reload_en  (ctrl_q.reload_en),
        .reload_val (reload_val),
        .clr        (clr),
        .cnt        (cnt_q),
        .wrap_evt   (wrap_evt)
    );

    ptmr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wdata    (reg_wdata[15:0]),
        .wrap_evt (wrap_evt),
        .ctrl     (ctrl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) wrap_pulse <= 1'b0;
        else     wrap_pulse <= wrap_evt;
    end

    assign tgl_out   = ctrl_q.out_en & ctrl_q.tgl;
    assign reg_rdata = (reg_addr == ADDR_CNT) ? cnt_q : DATA_W'(ctrl_img);
endmodule

// File: rtl/ptmr_core_chk.sv
module ptmr_core_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              run_en,
    input logic              cap_evt,
    input logic [15:0]       ctrl_img,
    input logic [DATA_W-1:0] cnt_q,
    input logic              wrap_evt,
    input logic              wrap_pulse
);
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (ctrl_img == 16'h0000 && cnt_q == '0));

    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !reg_wr_en && !cap_evt) |=> $stable(cnt_q));

    a_r4_wrap_value: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && !ctrl_img[15]) |=> (cnt_q == ($past(ctrl_img[7]) ? {DATA_W{1'b1}} : {DATA_W{1'b0}})));

    a_r6_capture_clear: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && ctrl_img[14] && !(reg_wr_en && reg_addr)) |=> (cnt_q == '0));

    a_r7_latch_flips: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && !(reg_wr_en && !reg_addr)) |=> (ctrl_img[10] != $past(ctrl_img[10])));

    a_r9_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> wrap_pulse);

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> !wrap_pulse);

    a_r10_cpu_write_wins: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr) |=> (cnt_q == $past(reg_wdata)));
endmodule

bind ptmr_core ptmr_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .run_en     (run_en),
    .cap_evt    (cap_evt),
    .ctrl_img   (ctrl_img),
    .cnt_q      (cnt_q),
    .wrap_evt   (wrap_evt),
    .wrap_pulse (wrap_pulse)
);

// File: tb/tb_ptmr_core.sv
module tb_ptmr_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        run_en = 1'b0;
    logic        cap_evt = 1'b0;
    logic [15:0] reload_val = '0;
    logic        tgl_out;
    logic        wrap_pulse;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ptmr_core dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_en(run_en),
        .cap_evt(cap_evt), .reload_val(reload_val), .tgl_out(tgl_out),
        .wrap_pulse(wrap_pulse)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 tgl_out, 2 wrap_pulse
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    item_t it;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expectations and compares against the design outputs
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            case (it.kind)
                0:       check(it.req, reg_rdata, it.exp);
                1:       check(it.req, {15'h0, tgl_out}, it.exp);
                default: check(it.req, {15'h0, wrap_pulse}, it.exp);
            endcase
        end
    end

    task automatic drv_wr(logic a, logic [15:0] d);
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr_en = 1'b0;
    endtask

    task automatic expect_rd(logic a, logic [15:0] e, string req);
        reg_addr = a;
        sbq.push_back('{0, e, req});
        @(posedge clk); #2;
    endtask

    task automatic expect_pin(int kind, logic e, string req);
        sbq.push_back('{kind, {15'h0, e}, req});
        @(posedge clk); #2;
    endtask

    task automatic pulse_cap();
        @(posedge clk); #2; cap_evt = 1'b1;
        @(posedge clk); #2; cap_evt = 1'b0;
    endtask

    // measure period and step size from three successive count changes
    task automatic measure(int n_exp, logic [15:0] step_exp, string req);
        logic [15:0] prev;
        int ch[3];
        int k = 0;
        int c = 0;
        reg_addr = 1'b1;
        run_en   = 1'b1;
        @(negedge clk);
        prev = reg_rdata;
        while (k < 3 && c < 200) begin
            @(negedge clk);
            c++;
            if (reg_rdata !== prev) begin
                check(req, reg_rdata - prev, step_exp);
                ch[k] = c;
                prev  = reg_rdata;
                k++;
            end
        end
        run_en = 1'b0;
        if (k < 3) check(req, 16'(k), 16'd3);
        else       check(req, 16'(ch[2] - ch[1]), 16'(n_exp));
        @(posedge clk); #2;
    endtask

    // run until the count shows target, stop, and report the wrap pulse there and one cycle later
    task automatic wait_val(logic [15:0] target, string req, output logic p0, output logic p1);
        int c = 0;
        reg_addr = 1'b1;
        run_en   = 1'b1;
        p0 = 1'b0; p1 = 1'b0;
        @(negedge clk);
        while (reg_rdata !== target && c < 300) begin
            @(negedge clk);
            c++;
        end
        run_en = 1'b0;
        check(req, reg_rdata, target);
        p0 = wrap_pulse;
        @(negedge clk);
        p1 = wrap_pulse;
        @(posedge clk); #2;
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic p0, p1;
        int   n;
        logic [15:0] base;

        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state, R8 and R9 outputs quiet
        expect_rd(1'b0, 16'h0000, "R1");
        expect_rd(1'b1, 16'h0000, "R1");
        expect_pin(1, 1'b0, "R8");
        expect_pin(2, 1'b0, "R9");

        // R1 read-back, unused control bits read 0
        drv_wr(1'b1, 16'h1234);
        expect_rd(1'b1, 16'h1234, "R1");
        drv_wr(1'b0, 16'hFFFF);
        expect_rd(1'b0, 16'hDE80, "R1");
        // R7 software sets latch, R8 output enabled
        expect_pin(1, 1'b1, "R8");
        drv_wr(1'b0, 16'h0400);
        expect_pin(1, 1'b0, "R8");
        expect_rd(1'b0, 16'h0400, "R7");

        // R2 hold while stopped
        repeat (40) @(posedge clk);
        #2;
        expect_rd(1'b1, 16'h1234, "R2");

        // R3 periods for every divider code, R2 single up steps
        drv_wr(1'b0, 16'h0000); measure(4,  16'h0001, "R3");
        drv_wr(1'b0, 16'h0800); measure(2,  16'h0001, "R3");
        drv_wr(1'b0, 16'h1000); measure(16, 16'h0001, "R3");
        drv_wr(1'b0, 16'h1800); measure(8,  16'h0001, "R3");

        // R12 down counting
        drv_wr(1'b0, 16'h0880); measure(2, 16'hFFFF, "R12");

        // R11 prescaler restart on divider change
        drv_wr(1'b0, 16'h0000);
        run_en = 1'b1;
        repeat (10) @(posedge clk);
        #2;
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h1000;
        @(posedge clk); #2;
        reg_wr_en = 1'b0; reg_addr = 1'b1;
        @(negedge clk);
        base = reg_rdata;
        n = 1;
        while (reg_rdata === base && n < 100) begin
            @(negedge clk);
            n++;
        end
        run_en = 1'b0;
        check("R11", 16'(n), 16'd18);
        @(posedge clk); #2;

        // R4 overflow wraps to zero, R7 latch toggles, R9 one-cycle pulse
        drv_wr(1'b0, 16'h0800);
        drv_wr(1'b1, 16'hFFFE);
        wait_val(16'h0000, "R4", p0, p1);
        check("R9", {15'h0, p0}, 16'h0001);
        check("R9", {15'h0, p1}, 16'h0000);
        expect_rd(1'b0, 16'h0C00, "R7");

        // R4 underflow without reload
        drv_wr(1'b0, 16'h0880);
        drv_wr(1'b1, 16'h0001);
        wait_val(16'hFFFF, "R4", p0, p1);
        check("R9", {15'h0, p0}, 16'h0001);

        // R5 underflow with reload
        reload_val = 16'h0100;
        drv_wr(1'b0, 16'h8880);
        drv_wr(1'b1, 16'h0001);
        wait_val(16'h0100, "R5", p0, p1);
        check("R9", {15'h0, p0}, 16'h0001);
        expect_rd(1'b0, 16'h8C80, "R7");

        // R5 overflow with reload
        reload_val = 16'h00AA;
        drv_wr(1'b0, 16'h8800);
        drv_wr(1'b1, 16'hFFFF);
        wait_val(16'h00AA, "R5", p0, p1);
        expect_rd(1'b0, 16'h8C00, "R7");

        // R6 capture clear enabled and disabled
        drv_wr(1'b0, 16'h4800);
        drv_wr(1'b1, 16'h5555);
        pulse_cap();
        expect_rd(1'b1, 16'h0000, "R6");
        drv_wr(1'b0, 16'h0800);
        drv_wr(1'b1, 16'h5555);
        pulse_cap();
        expect_rd(1'b1, 16'h5555, "R6");

        // R10 CPU count write wins over ticks
        run_en = 1'b1;
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h2000;
        @(posedge clk); #2;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R10", reg_rdata, 16'h2000);
        end
        @(posedge clk); #2;
        reg_wr_en = 1'b0; run_en = 1'b0;

        // R10 capture clear wins over counting and wrap
        drv_wr(1'b0, 16'h4800);
        drv_wr(1'b1, 16'hFFFF);
        run_en = 1'b1; cap_evt = 1'b1;
        @(posedge clk); #2;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R10", reg_rdata, 16'h0000);
            check("R10", {15'h0, wrap_pulse}, 16'h0000);
        end
        @(posedge clk); #2;
        cap_evt = 1'b0; run_en = 1'b0;
        expect_rd(1'b0, 16'h4800, "R10");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule